// File: doc/BRIEF.md
# Direct-Page Bit Test and Set Engine

This block carries out the single-bit instructions that work on a byte in the direct page, where the upper address byte is zero. Once `start_i` is accepted, the engine fetches the instruction bytes itself through a fetch port, starting at the program counter it was given.

Two kinds of instruction are handled:

- **Test forms** read the addressed byte, test one bit of it and either take a relative branch or fall through.
- **Set forms** read the addressed byte, OR in a one-hot mask and write the byte back.

The opcode supplies both the bit number and the sense of the test.

When the instruction ends, `done_o` pulses for one cycle. From the next cycle on, `pc_o` holds the address of the next instruction and `carry_o` holds the updated carry. A surrounding CPU uses the engine as an execution slot: it starts the engine with the current PC and waits for the done pulse.

Top module: `bit_branch_unit`

## Requirements
- R1: While reset is held and after it is released, with no start: busy_o, done_o and mem_we_o are 0, carry_o is 0 and pc_o is 0.
- R2: A start pulse is accepted only while busy_o is 0, and it loads pc_i as the instruction address. A start pulse while busy_o is 1 has no effect on the running instruction or on its results.
- R3: Opcodes 0x00..0x0F are test forms. The tested bit is opcode[3:1]. An even opcode branches when that bit is 1, and an odd opcode branches when it is 0.
- R4: A test form occupies three bytes: opcode, direct address, signed offset. The next PC is PC+3, plus the sign-extended offset when the branch is taken. Addition wraps modulo 2^PC_W.
- R5: After a test form, carry_o equals the tested bit. Set forms and unsupported opcodes leave carry_o unchanged.
- R6: The operand is read from address {0, direct byte}. A test form performs no memory write.
- R7: Opcodes 0x10+2n (0x10..0x1E) write the addressed byte back exactly once, with bit n set and the other seven bits unchanged. The next PC is PC+2.
- R8: For test and set forms, done_o is high in exactly the fifth cycle after the start is accepted, and only for that one cycle.
- R9: Any other opcode (odd values in 0x11..0x1F, and 0x20..0xFF) performs no write and leaves carry_o unchanged. The next PC is PC+1 and done_o rises in the second cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an instruction at pc_i |
| pc_i | input | PC_W | Address of the opcode byte |
| fetch_addr_o | output | PC_W | Instruction byte address |
| fetch_data_i | input | 8 | Instruction byte at fetch_addr_o, same cycle |
| mem_addr_o | output | ADDR_W | Data memory address |
| mem_rdata_i | input | 8 | Data byte at mem_addr_o, same cycle |
| mem_wdata_o | output | 8 | Data to write |
| mem_we_o | output | 1 | Write strobe, captured on the rising clock edge |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Final-cycle strobe |
| pc_o | output | PC_W | Next instruction address |
| carry_o | output | 1 | Carry flag |

## Verification
The bench builds the engine with PC_W=16 and ADDR_W=16. The 16-bit program counter lets random start addresses near 0xFFFF show that both forward and backward branch targets wrap. The 16-bit data address shows that every operand access keeps the upper byte at zero. Opcodes are drawn over the whole byte range, so all sixteen test encodings, all eight set encodings and the unsupported values are mixed with random bytes and offsets.

// File: rtl/bbu_pkg.sv
package bbu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_DIR, ST_RD, ST_FOURTH, ST_LAST
  } bbu_state_e;

  typedef enum logic [1:0] {K_NONE, K_TEST, K_SET} bbu_kind_e;

  typedef struct packed {
    bbu_kind_e   kind;
    logic [2:0]  bit_idx;
    logic        br_on_one;
  } bbu_dec_t;
endpackage

// File: rtl/bbu_decode.sv
module bbu_decode
  import bbu_pkg::*;
(
  input  logic [7:0] opcode_i,
  output bbu_dec_t   dec_o
);
  always_comb begin
    dec_o.bit_idx   = opcode_i[3:1];
    dec_o.br_on_one = ~opcode_i[0];
    if (opcode_i[7:4] == 4'h0)                     dec_o.kind = K_TEST;
    else if (opcode_i[7:4] == 4'h1 && !opcode_i[0]) dec_o.kind = K_SET;
    else                                            dec_o.kind = K_NONE;
  end
endmodule

// File: rtl/bbu_bit_alu.sv
module bbu_bit_alu #(
  parameter int PC_W = 16
) (
  input  logic [7:0]      byte_i,
  input  logic [2:0]      bit_idx_i,
  input  logic            br_on_one_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [7:0]      off_i,
  output logic            bit_o,
  output logic            taken_o,
  output logic [7:0]      set_byte_o,
  output logic [PC_W-1:0] next_pc_o
);
  localparam int EXT_W = PC_W - 8;

  logic [7:0]      mask;
  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] fall_pc;

  always_comb begin
    mask       = 8'd1 << bit_idx_i;
    bit_o      = |(byte_i & mask);
    taken_o    = (bit_o == br_on_one_i);
    set_byte_o = byte_i | mask;
    off_ext    = {{EXT_W{off_i[7]}}, off_i};
    fall_pc    = pc_i + PC_W'(3);
    next_pc_o  = taken_o ? fall_pc + off_ext : fall_pc;
  end
endmodule

// File: rtl/bbu_seq.sv
module bbu_seq
  import bbu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  bbu_kind_e  kind_i,
  output bbu_state_e state_o
);
  bbu_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      ST_IDLE:   if (start_i) state_d = ST_OPC;
      ST_OPC:    state_d = (kind_i == K_NONE) ? ST_LAST : ST_DIR;
      ST_DIR:    state_d = ST_RD;
      ST_RD:     state_d = ST_FOURTH;
      ST_FOURTH: state_d = ST_LAST;
      ST_LAST:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= state_d;
endmodule

// File: rtl/bit_branch_unit.sv
module bit_branch_unit
  import bbu_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic [PC_W-1:0]   fetch_addr_o,
  input  logic [7:0]        fetch_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_rdata_i,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              carry_o
);
  localparam int HI_W = ADDR_W - 8;

  bbu_state_e      state;
  bbu_dec_t        dec;
  logic [7:0]      op_q, dd_q, byte_q, off_q, op_sel, set_byte;
  logic [PC_W-1:0] pc_q, next_pc;
  logic            carry_q, tbit, taken;

  assign op_sel = (state == ST_OPC) ? fetch_data_i : op_q;

  bbu_decode i_dec (.opcode_i(op_sel), .dec_o(dec));

  bbu_seq i_seq (
    .clk_i, .rst_ni, .start_i, .kind_i(dec.kind), .state_o(state)
  );

  bbu_bit_alu #(.PC_W(PC_W)) i_alu (
    .byte_i(byte_q), .bit_idx_i(dec.bit_idx), .br_on_one_i(dec.br_on_one),
    .pc_i(pc_q), .off_i(off_q), .bit_o(tbit), .taken_o(taken),
    .set_byte_o(set_byte), .next_pc_o(next_pc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0; op_q <= '0; dd_q <= '0; byte_q <= '0; off_q <= '0; carry_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:   if (start_i) pc_q <= pc_i;
        ST_OPC:    op_q   <= fetch_data_i;
        ST_DIR:    dd_q   <= fetch_data_i;
        ST_RD:     byte_q <= mem_rdata_i;
        ST_FOURTH: if (dec.kind == K_TEST) off_q <= fetch_data_i;
        ST_LAST: begin
          unique case (dec.kind)
            K_TEST: begin pc_q <= next_pc; carry_q <= tbit; end
            K_SET:  pc_q <= pc_q + PC_W'(2);
            default: pc_q <= pc_q + PC_W'(1);
          endcase
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_DIR:    fetch_addr_o = pc_q + PC_W'(1);
      ST_FOURTH: fetch_addr_o = pc_q + PC_W'(2);
      default:   fetch_addr_o = pc_q;
    endcase
  end

  // direct page: upper address byte forced to zero
  assign mem_addr_o  = (state == ST_RD || state == ST_FOURTH) ? {{HI_W{1'b0}}, dd_q} : '0;
  assign mem_we_o    = (state == ST_FOURTH) && (dec.kind == K_SET);
  assign mem_wdata_o = set_byte;
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_LAST);
  assign pc_o        = pc_q;
  assign carry_o     = carry_q;

  assert_start_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_fifth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(busy_o, 3)) |-> ($past(start_i, 5) && !$past(busy_o, 5)));

  assert_write_page_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:8] == '0) && (mem_addr_o == $past(mem_addr_o)));

  assert_keep_bits_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ((mem_wdata_o & $past(mem_rdata_i)) == $past(mem_rdata_i))
                 && ($countones(mem_wdata_o ^ $past(mem_rdata_i)) <= 1));

  assert_carry_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(carry_o) |-> $past(done_o));
endmodule

// File: tb/test_bit_branch_unit.sv
`timescale 1ns/1ps
module test_bit_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] pc_in = '0;
  logic [15:0] fetch_addr, mem_addr, pc_out;
  logic [7:0]  fetch_data, mem_rdata, mem_wdata;
  logic        mem_we, busy, done, carry;

  logic [7:0] prog [65536];
  logic [7:0] dmem [256];
  int total = 0, bad = 0, wr_cnt = 0, wr_hi = 0;
  logic exp_carry = 1'b0;

  always #2 clk = ~clk;

  assign fetch_data = prog[fetch_addr];
  assign mem_rdata  = dmem[mem_addr[7:0]];

  bit_branch_unit i_bit_branch_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pc_i(pc_in),
    .fetch_addr_o(fetch_addr), .fetch_data_i(fetch_data),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .busy_o(busy), .done_o(done), .pc_o(pc_out), .carry_o(carry)
  );

  always @(posedge clk) if (rst_n && mem_we) begin
    dmem[mem_addr[7:0]] <= mem_wdata;
    wr_cnt <= wr_cnt + 1;
    if (mem_addr[15:8] != 8'h00) wr_hi <= wr_hi + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [7:0] op);
    if (op[7:4] == 4'h0) return 1;
    if (op[7:4] == 4'h1 && !op[0]) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] model_pc(input logic [7:0] op, input logic [15:0] pc,
                                           input logic [7:0] rr, input logic [7:0] b);
    logic bv;
    int k;
    k  = kind_of(op);
    bv = b[op[3:1]];
    if (k == 1) return pc + 16'd3 + (((op[0] ? !bv : bv)) ? {{8{rr[7]}}, rr} : 16'd0);
    if (k == 2) return pc + 16'd2;
    return pc + 16'd1;
  endfunction

  task automatic run(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] dd,
                     input logic [7:0] rr, input logic [7:0] b, input bit poke);
    int n, k, w0;
    logic [7:0] exp_b;
    logic [15:0] exp_pc;
    k = kind_of(op);
    prog[pc] = op; prog[pc + 16'd1] = dd; prog[pc + 16'd2] = rr;
    dmem[dd] = b;
    exp_pc = model_pc(op, pc, rr, b);
    exp_b  = (k == 2) ? (b | (8'd1 << op[3:1])) : b;
    if (k == 1) exp_carry = b[op[3:1]];
    w0 = wr_cnt;
    @(negedge clk);
    start = 1'b1; pc_in = pc;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin start = 1'b1; pc_in = pc ^ 16'h5a5a; end
      else start = 1'b0;
    end
    start = 1'b0;
    // R8 / R9: done in fifth (or second) cycle after accept
    chk(n == ((k == 0) ? 2 : 5), (k == 0) ? "R9 cycles" : "R8 cycles", n, (k == 0) ? 2 : 5);
    @(negedge clk);
    chk(!done, "R8 single pulse", done, 0);
    chk(pc_out == exp_pc, (k == 1) ? "R3/R4 next pc" : (k == 2) ? "R7 next pc" : "R9 next pc",
        pc_out, exp_pc);
    chk(carry == exp_carry, "R5 carry", carry, exp_carry);
    chk(dmem[dd] == exp_b, (k == 2) ? "R7 written byte" : "R6 byte untouched", dmem[dd], exp_b);
    chk(wr_cnt - w0 == ((k == 2) ? 1 : 0), (k == 2) ? "R7 one write" : "R6/R9 no write",
        wr_cnt - w0, (k == 2) ? 1 : 0);
    if (poke) chk(!busy && pc_out == exp_pc, "R2 start while busy ignored", pc_out, exp_pc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 65536; i++) prog[i] = 8'h00;
    for (int i = 0; i < 256; i++) dmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && !carry && pc_out == 0, "R1 reset state",
        {busy, done, mem_we, carry}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !mem_we && pc_out == 0, "R1 idle after reset", pc_out, 0);

    run(8'h0E, 16'h1000, 8'h40, 8'hF0, 8'h80, 0); // R3 bit7 set, even: taken backward R4
    run(8'h01, 16'h2000, 8'h41, 8'h10, 8'hFE, 0); // R3 bit0 clear, odd: taken
    run(8'h01, 16'h2100, 8'h42, 8'h10, 8'h01, 0); // R3 odd, bit set: not taken
    run(8'h06, 16'hFFFE, 8'h43, 8'h7F, 8'h08, 0); // R4 wrap forward
    run(8'h1E, 16'h3000, 8'h44, 8'h00, 8'h7F, 0); // R7 set bit7
    run(8'h14, 16'h3100, 8'h45, 8'h00, 8'h04, 0); // R7 already set
    run(8'h11, 16'h3200, 8'h46, 8'h00, 8'h00, 0); // R9 unsupported odd
    run(8'hA5, 16'h3300, 8'h47, 8'h00, 8'h00, 0); // R9 outside range
    run(8'h08, 16'h4000, 8'h48, 8'h22, 8'h10, 1); // R2 start while busy

    for (int i = 0; i < 300; i++) begin
      logic [7:0] op;
      op = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 32);
      run(op, 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 0);
    end
    chk(wr_hi == 0, "R6 upper address byte zero", wr_hi, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule